// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a programmable down-counter that raises a local interrupt request when it runs out. Software loads a start value, chooses a clock divider and sets up a timer entry that holds an interrupt vector, a mask bit and a mode bit. The counter then counts down once for every power-of-two group of base ticks. A base tick is a one-cycle clock-enable that the rest of the chip supplies.

In one-shot mode the counter stops at zero after a single expiry. In periodic mode it starts again from the loaded value on the step after zero, so each period lasts the start value plus one steps. Each expiry gives a one-cycle request on `irq_req` with the vector on `irq_vector`, unless the entry is masked. The current count, the start value, the divider setting and the timer entry can all be read through a combinational read port.

Top module: `lapic_cd_timer`

## Requirements
- R1: A write to the divider register (`wr_sel`=1) keeps only data bits 3, 1 and 0. Reading it back (`rd_sel`=1) returns the written value AND 0xB.
- R2: The divider code v is {cfg[3], cfg[1:0]} and the shift is (v+1) mod 8. The count falls by one for every 2^shift base ticks, counted from the last start-value write. Examples: cfg 0xB divides by 1, cfg 0x0 by 2, cfg 0x3 by 16, cfg 0x8 by 32.
- R3: The timer entry (`wr_sel`=2) uses bit 17 for periodic mode, bit 16 for the mask and bits 7:0 for the vector. In one-shot mode (bit 17 = 0) the count is start − elapsed until it reaches 0, and then it stays at 0.
- R4: In periodic mode the count is start − (elapsed mod (start+1)). On the step after 0 it reloads the start value.
- R5: When a step moves the count from 1 to 0, `irq_req` is high for one cycle after that edge and `irq_vector` carries entry bits 7:0. This happens only if the mask bit is 0. A masked entry gives no request.
- R6: A start-value write (`wr_sel`=0) loads the count at once, clears the divider phase and restarts timing. A base tick in the same cycle as the write is ignored.
- R7: A start value of zero stops the timer. The count stays at 0 and no request is raised.
- R8: The count changes only on cycles where `base_tick` is high or a start value is written.
- R9: A timer-entry write takes effect at the next step. A one-shot timer held at 0 that is switched to periodic reloads the start value on the next step.
- R10: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the count, the start value and the divider read 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start value, 1 divider, 2 timer entry |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read source: 0 start value, 1 divider, 2 timer entry, 3 current count |
| rd_data | output | DATA_W | Combinational read data |
| base_tick | input | 1 | Clock-enable base tick |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector that goes with `irq_req` |

## Verification
A register write shows on `rd_data` after the single edge that samples the write. The count moves on each edge where `base_tick` is high and the divider phase has completed. The request is registered, so it rises at the same edge that takes the count from 1 to 0 and falls one cycle later. The bench drives inputs on the falling edge and reads results on a later falling edge. It then waits a short settle delay, so each value it reads was produced by the rising edges it has counted. The expected counts are worked out from the elapsed-tick formulas for each divider code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SEL_INIT = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_LVT  = 2'd2,
      SEL_CUR  = 2'd3
   } tmr_sel_e;

   localparam int          ENT_MASK_BIT = 16;
   localparam int          ENT_PER_BIT  = 17;
   localparam int          VEC_W        = 8;
   localparam int          SHIFT_W      = 3;
   localparam logic [3:0]  DIV_KEEP     = 4'hB;

   function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
      logic [SHIFT_W-1:0] code;
      code = {cfg[3], cfg[1:0]};
      return code + 3'd1;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SHIFT_W = 3,
   localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               enable,
   input  logic               tick,
   input  logic [SHIFT_W-1:0] shift,
   output logic               step
);
   logic [PRE_W-1:0] phase_q;
   logic [PRE_W-1:0] limit;
   logic             wrap;

   if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift
      $error("tmr_prescale: SHIFT_W out of range");
   end

   for (genvar i = 0; i < PRE_W; i++) begin : g_limit
      assign limit[i] = (i < int'(shift));
   end

   assign wrap = (phase_q >= limit);
   assign step = enable & tick & ~restart & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 phase_q <= '0;
      else if (restart)           phase_q <= '0;
      else if (enable && tick)    phase_q <= wrap ? '0 : phase_q + 1'b1;
   end

   p_idle_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !step);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             step,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_count: CNT_W must be at least 2");
   end

   assign count  = cnt_q;
   assign expire = step & ~restart & (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (restart)              cnt_q <= load_val;
      else if (step) begin
         if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
         else if (periodic)          cnt_q <= reload_val;
      end
   end

   p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !periodic && !restart) |=> (cnt_q == '0));
   p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   p_stable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !restart) |=> $stable(cnt_q));
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && periodic && cnt_q == '0) |=> (cnt_q == $past(reload_val)));
endmodule

// File: rtl/lapic_cd_timer.sv
module lapic_cd_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              base_tick,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector
);
   if (CNT_W > DATA_W || DATA_W < 18) begin : g_bad_width
      $error("lapic_cd_timer: widths do not fit the register layout");
   end

   logic [CNT_W-1:0] init_q;
   logic [3:0]       div_q;
   logic [VEC_W-1:0] vec_q;
   logic             mask_q, per_q;
   logic             irq_q;
   logic [VEC_W-1:0] irq_vec_q;
   logic             restart, step, expire;
   logic [CNT_W-1:0] cur_cnt;
   logic [SHIFT_W-1:0] shift;

   assign restart = wr_en && (wr_sel == SEL_INIT);
   assign shift   = div_shift(div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         div_q  <= '0;
         vec_q  <= '0;
         mask_q <= 1'b1;
         per_q  <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_INIT: init_q <= wr_data[CNT_W-1:0];
            SEL_DIV:  div_q  <= wr_data[3:0] & DIV_KEEP;
            SEL_LVT: begin
               vec_q  <= wr_data[VEC_W-1:0];
               mask_q <= wr_data[ENT_MASK_BIT];
               per_q  <= wr_data[ENT_PER_BIT];
            end
            default: ;
         endcase
      end
   end

   tmr_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .enable(init_q != '0), .tick(base_tick), .shift(shift), .step(step)
   );

   tmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .load_val(wr_data[CNT_W-1:0]), .reload_val(init_q),
      .step(step), .periodic(per_q), .count(cur_cnt), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         irq_vec_q <= '0;
      end else begin
         irq_q <= expire & ~mask_q;
         if (expire) irq_vec_q <= vec_q;
      end
   end

   assign irq_req    = irq_q;
   assign irq_vector = irq_vec_q;

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_INIT: rd_data = DATA_W'(init_q);
         SEL_DIV:  rd_data = DATA_W'(div_q);
         SEL_LVT: begin
            rd_data[VEC_W-1:0]   = vec_q;
            rd_data[ENT_MASK_BIT] = mask_q;
            rd_data[ENT_PER_BIT]  = per_q;
         end
         default:  rd_data = DATA_W'(cur_cnt);
      endcase
   end

   p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |=> !irq_req);
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);
   p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (init_q == '0 && !wr_en) |=> !irq_req);
   p_div_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q & ~DIV_KEEP) == 4'h0);
endmodule

// File: tb/lapic_cd_timer_tb.sv
module lapic_cd_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;
   logic        base_tick = 1'b0;
   logic        irq_req;
   logic [7:0]  irq_vector;

   int vectors = 0;
   int miscompares = 0;
   int irq_seen = 0;
   logic [7:0] last_vec = '0;
   bit done = 1'b0;

   lapic_cd_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .base_tick(base_tick), .irq_req(irq_req), .irq_vector(irq_vector)
   );

   always #4 clk = ~clk;

   always @(negedge clk) if (irq_req) begin
      irq_seen = irq_seen + 1;
      last_vec = irq_vector;
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #2;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      base_tick = 1'b1;
      repeat (n) @(negedge clk);
      base_tick = 1'b0;
      #2;
   endtask

   task automatic setup(input logic [31:0] lvt, input logic [31:0] div, input logic [31:0] init);
      wr(2'd0, 32'd0);
      wr(2'd2, lvt);
      wr(2'd1, div);
      wr(2'd0, init);
      irq_seen = 0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2'd2, v); check("R10 entry", v, 32'h0001_0000);
      rd(2'd3, v); check("R10 count", v, 32'd0);
      rd(2'd0, v); check("R10 start", v, 32'd0);
      rd(2'd1, v); check("R10 div", v, 32'd0);
      check("R10 irq", {31'd0, irq_req}, 32'd0);
   endtask

   task automatic t_div_mask;
      logic [31:0] v;
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R1 div keep", v, 32'hB);
      wr(2'd1, 32'h4);
      rd(2'd1, v); check("R1 div bit2 drop", v, 32'h0);
   endtask

   task automatic t_divider;
      logic [31:0] v;
      setup(32'h0001_0000, 32'hB, 32'd10); ticks(3);
      rd(2'd3, v); check("R2 div1", v, 32'd7);
      setup(32'h0001_0000, 32'h0, 32'd10); ticks(5);
      rd(2'd3, v); check("R2 div2", v, 32'd8);
      setup(32'h0001_0000, 32'h3, 32'd10); ticks(40);
      rd(2'd3, v); check("R2 div16", v, 32'd8);
      setup(32'h0001_0000, 32'h8, 32'd100); ticks(95);
      rd(2'd3, v); check("R2 div32", v, 32'd98);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      setup(32'h0000_0042, 32'hB, 32'd5); ticks(5);
      rd(2'd3, v); check("R3 oneshot zero", v, 32'd0);
      check("R5 irq count", irq_seen, 32'd1);
      check("R5 vector", {24'd0, last_vec}, 32'h42);
      ticks(10);
      rd(2'd3, v); check("R3 oneshot hold", v, 32'd0);
      check("R3 no repeat irq", irq_seen, 32'd1);
   endtask

   task automatic t_periodic;
      logic [31:0] v;
      setup(32'h0002_0055, 32'hB, 32'd4); ticks(4);
      rd(2'd3, v); check("R4 at zero", v, 32'd0);
      ticks(1);
      rd(2'd3, v); check("R4 reload", v, 32'd4);
      ticks(14);
      rd(2'd3, v); check("R4 mod count", v, 32'd0);
      check("R4 irq count", irq_seen, 32'd4);
      check("R5 vector", {24'd0, last_vec}, 32'h55);
   endtask

   task automatic t_masked;
      logic [31:0] v;
      setup(32'h0003_0011, 32'hB, 32'd3); ticks(8);
      rd(2'd3, v); check("R5 masked count", v, 32'd3);
      check("R5 masked irq", irq_seen, 32'd0);
   endtask

   task automatic t_restart;
      logic [31:0] v;
      setup(32'h0001_0000, 32'hB, 32'd10); ticks(4);
      rd(2'd3, v); check("R6 before", v, 32'd6);
      wr(2'd0, 32'd20);
      rd(2'd3, v); check("R6 loaded", v, 32'd20);
      rd(2'd0, v); check("R6 start rd", v, 32'd20);
      ticks(3);
      rd(2'd3, v); check("R6 after", v, 32'd17);
      setup(32'h0001_0000, 32'h0, 32'd10); ticks(1);
      wr(2'd0, 32'd10); ticks(1);
      rd(2'd3, v); check("R6 phase cleared", v, 32'd10);
      ticks(1);
      rd(2'd3, v); check("R6 phase step", v, 32'd9);
      // tick during the write cycle is ignored
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd7; base_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; base_tick = 1'b0; #2;
      rd(2'd3, v); check("R6 tick ignored", v, 32'd7);
   endtask

   task automatic t_zero;
      logic [31:0] v;
      setup(32'h0002_0033, 32'hB, 32'd0); ticks(20);
      rd(2'd3, v); check("R7 zero count", v, 32'd0);
      check("R7 zero irq", irq_seen, 32'd0);
   endtask

   task automatic t_idle;
      logic [31:0] v;
      setup(32'h0001_0000, 32'hB, 32'd9);
      repeat (10) @(negedge clk);
      #2;
      rd(2'd3, v); check("R8 idle", v, 32'd9);
   endtask

   task automatic t_lvt_reeval;
      logic [31:0] v;
      setup(32'h0000_0021, 32'hB, 32'd3); ticks(3);
      rd(2'd3, v); check("R9 oneshot end", v, 32'd0);
      wr(2'd2, 32'h0002_0021); ticks(1);
      rd(2'd3, v); check("R9 reload after switch", v, 32'd3);
      check("R9 irq count", irq_seen, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_div_mask();
      t_divider();
      t_oneshot();
      t_periodic();
      t_masked();
      t_restart();
      t_zero();
      t_idle();
      t_lvt_reeval();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            vectors++; miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule